// File: doc/BRIEF.md
# Debug run-control and emulation controller

This block holds the run and privilege state that on-chip debug needs. It tracks whether the core is running or halted, whether it is in emulator mode and whether it is at supervisor level. It takes retire, trace-exception, HALT-instruction, GO and interrupt-pending events from the core and the debug port, together with a set of static control bits. From these it produces the halted, emulator and supervisor flags, an interrupt-accept signal and a one-cycle privilege-violation pulse. It also produces the address-space attributes (transfer type and transfer modifier) and the local memory enables for each bus reference.

The block supports single stepping. With stepping on, every instruction that retires while the core runs halts the core, and each GO lets exactly one more instruction through. Emulator mode can be forced by a control bit or entered from a trace exception. When the remap bit is set, references made in emulator mode move to a dedicated address space, and the on-chip RAM and cache are switched off.

Top module: `dbg_runctl`

## Requirements
- R1: After reset the block is running (halted_o=0), not in emulator mode (emu_o=0), at supervisor level (super_o=1), has no violation pulse, and irq_take_o follows irq_pend_i.
- R2: While ctl_emu_i is 1 at a clock edge, emu_o is 1 from the next cycle on.
- R3: A trace_exc_i pulse sets super_o from the next cycle. If ctl_trc_i is 1 it also sets emu_o; if ctl_trc_i is 0, emu_o is left unchanged.
- R4: Outside emulator mode, tt_o=2'b00 and tm_o={super_o, fetch_i, !fetch_i}. Inside emulator mode with ctl_map_i=0, tt_o=2'b00 and tm_o is 3'b101 for data (fetch_i=0) and 3'b110 for fetch (fetch_i=1).
- R5: Inside emulator mode with ctl_map_i=1, tt_o=2'b10, tm_o is 3'b101 for data and 3'b110 for fetch, and sram_en_o=cache_en_o=0. In every other case both enables are 1.
- R6: A HALT request (halt_req_i=1) while running halts the core from the next cycle when it is legal. A request is legal when user_mode_i=0 (supervisor) or ctl_uhe_i=1.
- R7: A HALT request while running with user_mode_i=1 and ctl_uhe_i=0 raises priv_viol_o for exactly the next cycle and does not halt the core.
- R8: With ctl_ssm_i=1, a retire_i pulse while running halts the core from the next cycle.
- R9: go_i while halted resumes running from the next cycle. While halted, retire_i and halt_req_i are ignored. go_i while running has no effect.
- R10: irq_take_o = irq_pend_i AND not halted AND NOT(ctl_ssm_i AND ctl_ipi_i).
- R11: go_i accepted while halted with ctl_emu_i=0 leaves emulator mode. Outside emulator mode, each retire while running loads super_o from !user_mode_i. Emulator mode always reads as supervisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | Instruction retired pulse |
| trace_exc_i | input | 1 | Trace exception pulse |
| halt_req_i | input | 1 | HALT instruction executing |
| user_mode_i | input | 1 | Current privilege, 1 = user |
| go_i | input | 1 | GO command strobe |
| irq_pend_i | input | 1 | Interrupt pending |
| fetch_i | input | 1 | Current reference is an instruction fetch |
| ctl_map_i | input | 1 | Remap emulator references |
| ctl_trc_i | input | 1 | Route trace exceptions to emulator mode |
| ctl_emu_i | input | 1 | Force emulator mode |
| ctl_uhe_i | input | 1 | Allow HALT at user level |
| ctl_ssm_i | input | 1 | Single-step enable |
| ctl_ipi_i | input | 1 | Mask interrupts while stepping |
| halted_o | output | 1 | Core halted |
| emu_o | output | 1 | Emulator mode |
| super_o | output | 1 | Supervisor level |
| irq_take_o | output | 1 | Interrupt may be accepted |
| priv_viol_o | output | 1 | Illegal HALT pulse |
| tt_o | output | TT_W | Transfer type |
| tm_o | output | TM_W | Transfer modifier |
| sram_en_o | output | 1 | On-chip RAM enable |
| cache_en_o | output | 1 | Cache enable |

## Verification
The bench builds the block with its default parameters: a 2-bit type field, a 3-bit modifier field and the registered violation pulse. These defaults expose the exact attribute codes and the one-cycle delay of the pulse. Directed sequences step the core through forced and trace-entered emulator mode, legal and illegal HALTs, and several single-step GO rounds. A long biased random phase then mixes GO, retire and HALT in the same cycles while the core is halted or running.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
   localparam logic [1:0] TT_NORMAL = 2'b00;
   localparam logic [1:0] TT_EMUSPC = 2'b10;
   localparam logic [2:0] TM_SUP_DATA = 3'b101;
   localparam logic [2:0] TM_SUP_CODE = 3'b110;
endpackage

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl #(
   parameter bit VIOL_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic retire_i,
   input  logic halt_req_i,
   input  logic user_i,
   input  logic uhe_i,
   input  logic ssm_i,
   input  logic go_i,
   output logic halted_o,
   output logic go_acc_o,
   output logic viol_o
);
   logic halted_q;
   logic legal_halt;
   logic bad_halt;
   logic step_halt;

   assign legal_halt = halt_req_i && (!user_i || uhe_i);
   assign bad_halt   = halt_req_i && user_i && !uhe_i && !halted_q;
   assign step_halt  = ssm_i && retire_i;
   assign go_acc_o   = halted_q && go_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
      end else if (halted_q) begin
         if (go_i) halted_q <= 1'b0;
      end else if (legal_halt || step_halt) begin
         halted_q <= 1'b1;
      end
   end

   generate
      if (VIOL_REG) begin : g_viol_reg
         logic viol_q;
         always_ff @(posedge clk) begin
            if (!rst_n) viol_q <= 1'b0;
            else        viol_q <= bad_halt;
         end
         assign viol_o = viol_q;
      end else begin : g_viol_comb
         assign viol_o = bad_halt;
      end
   endgenerate

   assign halted_o = halted_q;
endmodule

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic trace_i,
   input  logic trc_i,
   input  logic emu_force_i,
   input  logic go_acc_i,
   input  logic retire_i,
   input  logic halted_i,
   input  logic user_i,
   output logic emu_o,
   output logic super_o
);
   logic emu_q;
   logic sup_q;
   logic emu_enter;

   assign emu_enter = emu_force_i || (trace_i && trc_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         emu_q <= 1'b0;
      end else if (emu_enter) begin
         emu_q <= 1'b1;
      end else if (go_acc_i) begin
         emu_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sup_q <= 1'b1;
      end else if (trace_i || emu_enter) begin
         sup_q <= 1'b1;
      end else if (retire_i && !halted_i && !emu_q) begin
         sup_q <= !user_i;
      end
   end

   assign emu_o   = emu_q;
   assign super_o = sup_q || emu_q;
endmodule

// File: rtl/dbg_attr_map.sv
module dbg_attr_map #(
   parameter int TT_W = 2,
   parameter int TM_W = 3
) (
   input  logic            emu_i,
   input  logic            super_i,
   input  logic            fetch_i,
   input  logic            map_i,
   output logic [TT_W-1:0] tt_o,
   output logic [TM_W-1:0] tm_o,
   output logic            sram_en_o,
   output logic            cache_en_o
);
   import dbg_runctl_pkg::*;

   logic remap;
   assign remap = emu_i && map_i;

   always_comb begin
      tt_o = TT_W'(TT_NORMAL);
      tm_o = TM_W'({super_i, fetch_i, !fetch_i});
      if (emu_i) begin
         tm_o = fetch_i ? TM_W'(TM_SUP_CODE) : TM_W'(TM_SUP_DATA);
         if (map_i) tt_o = TT_W'(TT_EMUSPC);
      end
   end

   assign sram_en_o  = !remap;
   assign cache_en_o = !remap;
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl #(
   parameter int TT_W     = 2,
   parameter int TM_W     = 3,
   parameter bit VIOL_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            retire_i,
   input  logic            trace_exc_i,
   input  logic            halt_req_i,
   input  logic            user_mode_i,
   input  logic            go_i,
   input  logic            irq_pend_i,
   input  logic            fetch_i,
   input  logic            ctl_map_i,
   input  logic            ctl_trc_i,
   input  logic            ctl_emu_i,
   input  logic            ctl_uhe_i,
   input  logic            ctl_ssm_i,
   input  logic            ctl_ipi_i,
   output logic            halted_o,
   output logic            emu_o,
   output logic            super_o,
   output logic            irq_take_o,
   output logic            priv_viol_o,
   output logic [TT_W-1:0] tt_o,
   output logic [TM_W-1:0] tm_o,
   output logic            sram_en_o,
   output logic            cache_en_o
);
   generate
      if (TT_W < 2) begin : g_bad_tt
         $error("dbg_runctl: TT_W must be at least 2");
      end
      if (TM_W < 3) begin : g_bad_tm
         $error("dbg_runctl: TM_W must be at least 3");
      end
   endgenerate

   logic go_acc;

   dbg_halt_ctl #(.VIOL_REG(VIOL_REG)) u_halt (
      .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .halt_req_i(halt_req_i),
      .user_i(user_mode_i), .uhe_i(ctl_uhe_i), .ssm_i(ctl_ssm_i), .go_i(go_i),
      .halted_o(halted_o), .go_acc_o(go_acc), .viol_o(priv_viol_o)
   );

   dbg_mode_ctl u_mode (
      .clk(clk), .rst_n(rst_n), .trace_i(trace_exc_i), .trc_i(ctl_trc_i),
      .emu_force_i(ctl_emu_i), .go_acc_i(go_acc), .retire_i(retire_i),
      .halted_i(halted_o), .user_i(user_mode_i), .emu_o(emu_o), .super_o(super_o)
   );

   dbg_attr_map #(.TT_W(TT_W), .TM_W(TM_W)) u_attr (
      .emu_i(emu_o), .super_i(super_o), .fetch_i(fetch_i), .map_i(ctl_map_i),
      .tt_o(tt_o), .tm_o(tm_o), .sram_en_o(sram_en_o), .cache_en_o(cache_en_o)
   );

   assign irq_take_o = irq_pend_i && !halted_o && !(ctl_ssm_i && ctl_ipi_i);
endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       retire_i,
   input logic       halt_req_i,
   input logic       user_mode_i,
   input logic       go_i,
   input logic       ctl_map_i,
   input logic       ctl_emu_i,
   input logic       ctl_uhe_i,
   input logic       ctl_ssm_i,
   input logic       halted_o,
   input logic       emu_o,
   input logic       priv_viol_o,
   input logic [1:0] tt_lo,
   input logic       sram_en_o
);
   // R2
   emu_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_emu_i |=> emu_o);
   // R7
   bad_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_req_i && user_mode_i && !ctl_uhe_i && !halted_o && !(retire_i && ctl_ssm_i))
      |=> (priv_viol_o && !halted_o));
   // R9
   hold_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && !go_i) |=> halted_o);
   // R9
   go_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_o && go_i) |=> !halted_o);
   // R5
   remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (emu_o && ctl_map_i) |-> (tt_lo == 2'b10 && !sram_en_o));
endmodule

bind dbg_runctl dbg_runctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .halt_req_i(halt_req_i),
   .user_mode_i(user_mode_i), .go_i(go_i), .ctl_map_i(ctl_map_i),
   .ctl_emu_i(ctl_emu_i), .ctl_uhe_i(ctl_uhe_i), .ctl_ssm_i(ctl_ssm_i),
   .halted_o(halted_o), .emu_o(emu_o), .priv_viol_o(priv_viol_o),
   .tt_lo(tt_o[1:0]), .sram_en_o(sram_en_o)
);

// File: tb/sim_dbg_runctl.sv
module sim_dbg_runctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic retire_i = 0, trace_exc_i = 0, halt_req_i = 0, user_mode_i = 0, go_i = 0;
   logic irq_pend_i = 0, fetch_i = 0;
   logic ctl_map_i = 0, ctl_trc_i = 0, ctl_emu_i = 0, ctl_uhe_i = 0, ctl_ssm_i = 0, ctl_ipi_i = 0;
   logic halted_o, emu_o, super_o, irq_take_o, priv_viol_o, sram_en_o, cache_en_o;
   logic [1:0] tt_o;
   logic [2:0] tm_o;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit m_halt, m_emu, m_sup, m_viol;

   always #10 clk = ~clk;

   dbg_runctl u0 (
      .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .trace_exc_i(trace_exc_i),
      .halt_req_i(halt_req_i), .user_mode_i(user_mode_i), .go_i(go_i),
      .irq_pend_i(irq_pend_i), .fetch_i(fetch_i), .ctl_map_i(ctl_map_i),
      .ctl_trc_i(ctl_trc_i), .ctl_emu_i(ctl_emu_i), .ctl_uhe_i(ctl_uhe_i),
      .ctl_ssm_i(ctl_ssm_i), .ctl_ipi_i(ctl_ipi_i), .halted_o(halted_o),
      .emu_o(emu_o), .super_o(super_o), .irq_take_o(irq_take_o),
      .priv_viol_o(priv_viol_o), .tt_o(tt_o), .tm_o(tm_o),
      .sram_en_o(sram_en_o), .cache_en_o(cache_en_o)
   );

   // behavioural reference, updated at each rising edge from the inputs held there
   always @(posedge clk) begin
      bit nh, ne, ns, nv;
      if (!rst_n) begin
         m_halt = 0; m_emu = 0; m_sup = 1; m_viol = 0;
      end else begin
         nh = m_halt; ne = m_emu; ns = m_sup; nv = 0;
         if (m_halt) begin
            if (go_i) begin
               nh = 0;
               if (!ctl_emu_i) ne = 0;
            end
         end else begin
            if (halt_req_i && user_mode_i && !ctl_uhe_i) nv = 1;
            else if (halt_req_i) nh = 1;
            if (ctl_ssm_i && retire_i) nh = 1;
            if (retire_i && !m_emu) ns = !user_mode_i;
         end
         if (ctl_emu_i) ne = 1;
         if (trace_exc_i) begin
            ns = 1;
            if (ctl_trc_i) ne = 1;
         end
         if (ne && !m_emu) ns = 1;
         m_halt = nh; m_emu = ne; m_sup = ns; m_viol = nv;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      bit esup;
      bit [1:0] ett;
      bit [2:0] etm;
      bit een;
      esup = m_sup || m_emu;
      ett = (m_emu && ctl_map_i) ? 2'b10 : 2'b00;
      etm = m_emu ? (fetch_i ? 3'b110 : 3'b101) : {esup, fetch_i, !fetch_i};
      een = !(m_emu && ctl_map_i);
      chk(halted_o === m_halt, tag, "halted", halted_o, m_halt);
      chk(emu_o === m_emu, tag, "emu", emu_o, m_emu);
      chk(super_o === esup, tag, "super", super_o, esup);
      chk(priv_viol_o === m_viol, "R7", "viol", priv_viol_o, m_viol);
      chk(tt_o === ett, m_emu ? "R5" : "R4", "tt", tt_o, ett);
      chk(tm_o === etm, "R4", "tm", tm_o, etm);
      chk(sram_en_o === een && cache_en_o === een, "R5", "enables",
          {sram_en_o, cache_en_o}, {een, een});
      chk(irq_take_o === (irq_pend_i && !m_halt && !(ctl_ssm_i && ctl_ipi_i)),
          "R10", "irq", irq_take_o, irq_pend_i && !m_halt && !(ctl_ssm_i && ctl_ipi_i));
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      @(negedge clk);
      #2;
      compare_all(tag);
   endtask

   task automatic pulse_clear();
      retire_i = 0; trace_exc_i = 0; halt_req_i = 0; go_i = 0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); #2;
      rst_n = 1;
      irq_pend_i = 1;
      tick("R1");
      chk(halted_o === 0 && emu_o === 0 && super_o === 1 && irq_take_o === 1,
          "R1", "reset state", {halted_o, emu_o, super_o, irq_take_o}, 4'b0011);
      // user level via retire (R11)
      user_mode_i = 1; retire_i = 1; tick("R11");
      pulse_clear(); tick("R11");
      chk(super_o === 0 && tm_o === 3'b001, "R11", "user data attr", {super_o, tm_o}, 4'b0001);
      fetch_i = 1; #1;
      chk(tm_o === 3'b010, "R4", "user code tm", tm_o, 3'b010);
      // illegal halt (R7)
      halt_req_i = 1; tick("R7");
      pulse_clear();
      chk(priv_viol_o === 1 && halted_o === 0, "R7", "viol pulse", {priv_viol_o, halted_o}, 2'b10);
      tick("R7");
      chk(priv_viol_o === 0, "R7", "pulse width", priv_viol_o, 0);
      // legal user halt with uhe (R6)
      ctl_uhe_i = 1; halt_req_i = 1; tick("R6");
      pulse_clear();
      chk(halted_o === 1 && irq_take_o === 0, "R6", "halted", {halted_o, irq_take_o}, 2'b10);
      retire_i = 1; halt_req_i = 1; tick("R9");
      pulse_clear();
      chk(halted_o === 1, "R9", "retire ignored while halted", halted_o, 1);
      go_i = 1; tick("R9"); pulse_clear();
      chk(halted_o === 0, "R9", "go releases", halted_o, 0);
      go_i = 1; tick("R9"); pulse_clear();
      chk(halted_o === 0, "R9", "go while running", halted_o, 0);
      // trace into supervisor, emu untouched (R3)
      trace_exc_i = 1; ctl_trc_i = 0; tick("R3"); pulse_clear();
      chk(super_o === 1 && emu_o === 0, "R3", "trace to super", {super_o, emu_o}, 2'b10);
      // trace into emulator (R3)
      trace_exc_i = 1; ctl_trc_i = 1; tick("R3"); pulse_clear();
      chk(emu_o === 1, "R3", "trace to emu", emu_o, 1);
      fetch_i = 0; #1;
      chk(tt_o === 2'b00 && tm_o === 3'b101 && sram_en_o === 1, "R4", "emu unmapped data",
          {tt_o, tm_o, sram_en_o}, 6'b001011);
      ctl_map_i = 1; fetch_i = 1; #1;
      chk(tt_o === 2'b10 && tm_o === 3'b110 && sram_en_o === 0 && cache_en_o === 0, "R5",
          "emu mapped fetch", {tt_o, tm_o, sram_en_o, cache_en_o}, 7'b1011000);
      // leave emulator by halt + go (R11)
      user_mode_i = 0; halt_req_i = 1; tick("R11"); pulse_clear();
      go_i = 1; tick("R11"); pulse_clear();
      chk(emu_o === 0 && sram_en_o === 1, "R11", "emu exit on go", {emu_o, sram_en_o}, 2'b01);
      // forced emulator (R2)
      ctl_emu_i = 1; tick("R2");
      chk(emu_o === 1, "R2", "forced emu", emu_o, 1);
      halt_req_i = 1; tick("R2"); pulse_clear();
      go_i = 1; tick("R2"); pulse_clear();
      chk(emu_o === 1, "R2", "emu held while forced", emu_o, 1);
      ctl_emu_i = 0; ctl_map_i = 0;
      halt_req_i = 1; tick("R11"); pulse_clear();
      go_i = 1; tick("R11"); pulse_clear();
      // single step (R8) with masked interrupts (R10)
      ctl_ssm_i = 1; ctl_ipi_i = 1; #1;
      chk(irq_take_o === 0, "R10", "masked in step", irq_take_o, 0);
      for (int k = 0; k < 3; k++) begin
         retire_i = 1; tick("R8"); pulse_clear();
         chk(halted_o === 1, "R8", "step halts", halted_o, 1);
         tick("R8");
         go_i = 1; tick("R8"); pulse_clear();
         chk(halted_o === 0, "R8", "go releases one", halted_o, 0);
      end
      ctl_ipi_i = 0; #1;
      chk(irq_take_o === 1, "R10", "step not masked", irq_take_o, 1);
      ctl_ssm_i = 0;
      retire_i = 1; tick("R8"); pulse_clear();
      chk(halted_o === 0, "R8", "no step halt", halted_o, 0);
      // biased random phase
      for (int n = 0; n < 4000; n++) begin
         retire_i    = ($urandom % 3) == 0;
         trace_exc_i = ($urandom % 23) == 0;
         halt_req_i  = ($urandom % 9) == 0;
         go_i        = ($urandom % 5) == 0;
         user_mode_i = $urandom % 2;
         irq_pend_i  = $urandom % 2;
         fetch_i     = $urandom % 2;
         ctl_map_i   = $urandom % 2;
         ctl_trc_i   = $urandom % 2;
         ctl_emu_i   = ($urandom % 31) == 0;
         ctl_uhe_i   = $urandom % 2;
         ctl_ssm_i   = ($urandom % 4) == 0;
         ctl_ipi_i   = $urandom % 2;
         tick("R9");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule